// File: doc/BRIEF.md
# Banked Voltage Monitor Channel Register File

This block holds the per-channel registers and the limit checks of a fourteen-channel voltage monitor. Software reaches it through a small byte-wide register port. A channel selector register chooses one channel. Four windowed offsets then give access to that channel's enable bit, its latest reading, its upper bound and its lower bound. A conversion engine outside the block delivers 8-bit samples, each tagged with a channel number and qualified by a strobe.

A sample for an enabled channel is captured in a one-stage check pipeline. On the following edge the sample replaces the channel's reading and is compared with the channel's two bounds. An out-of-window value sets that channel's sticky bit in a fourteen-bit event word. Two separate mask words gate the event word onto two interrupt lines: one for the management interrupt and one for the ordinary interrupt. Each fourteen-bit word is split across a pair of byte registers.

The capture stage is a two-state machine. S_IDLE holds no pending sample. S_CHECK holds one captured sample, which is committed on the edge that leaves the state. The transitions are: T_ACCEPT from S_IDLE to S_CHECK when an accepted sample arrives; T_CHAIN from S_CHECK to S_CHECK when a further accepted sample arrives while one is being committed; T_DONE from S_CHECK to S_IDLE when none arrives; and T_WAIT, the S_IDLE self-loop when no accepted sample arrives.

Top module: `vmon_bank_regs`

## Requirements
- R1: After reset the event word, both mask words, the selector, the rate and global config bytes, every reading and every enable are zero. Every upper bound is 0xFF, every lower bound is 0x00, and both interrupt outputs are low.
- R2: Offset 0x09 is a read/write 8-bit selector. Offsets 0x0A (enable), 0x0B (reading, read-only), 0x0C (upper bound) and 0x0D (lower bound) address the channel it names.
- R3: While the selector holds 14 or more, offsets 0x0A to 0x0D read 0x00 and writes to them change no channel.
- R4: Bit 0 of offset 0x0A is the channel enable, and bits 7:1 read 0. A sample for a disabled channel, or for a channel number of 14 or more, is dropped: no reading changes and no event bit is set.
- R5: A sample strobed at clock edge N for an enabled channel is visible at offset 0x0B after edge N+1.
- R6: A committed sample strictly greater than the upper bound, or strictly less than the lower bound, sets the channel's event bit. A sample equal to a bound does not. Channels 0 to 7 map to bits 7:0 of offset 0x00, and channels 8 to 13 map to bits 5:0 of offset 0x01, whose bits 7:6 read 0.
- R7: Event bits are sticky and are cleared by writing 1 to them. When a set and a clear fall on the same edge, the set wins.
- R8: The management interrupt output is the OR of the event bits ANDed with the mask at offsets 0x02/0x03. The ordinary interrupt output uses the mask at 0x04/0x05. Both masks use the event word's bit layout.
- R9: Offsets 0x07 (conversion rate) and 0x08 (global config) are plain 8-bit read/write bytes with no effect on the checks. Offsets 0x06, 0x0E and 0x0F read 0x00.
- R10: The capture stage follows the transitions T_WAIT, T_ACCEPT, T_CHAIN and T_DONE. Samples strobed on consecutive edges are all committed, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| smp_valid | input | 1 | Sample strobe from the conversion engine |
| smp_chan | input | 4 | Channel number of the sample |
| smp_data | input | 8 | Sample value |
| smi_o | output | 1 | Masked event output, management mask |
| irq_o | output | 1 | Masked event output, interrupt mask |

## Verification
The assertions assume that the register port and the sample strobe are driven synchronously and are stable around the rising edge. They also assume that a sample's channel field may take any 4-bit value, including the out-of-range numbers 14 and 15. The stimulus changes every input only on the falling edge. It draws channel numbers, selector values, bounds and data from the full value ranges, so out-of-range channels, selectors of 14 and above, values equal to a bound, and same-edge set/clear collisions all occur. Directed sequences add back-to-back samples, which exercise T_CHAIN.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
    typedef enum logic [0:0] {S_IDLE = 1'b0, S_CHECK = 1'b1} vm_state_e;

    localparam logic [3:0] OFS_EVT_LO = 4'h0;
    localparam logic [3:0] OFS_EVT_HI = 4'h1;
    localparam logic [3:0] OFS_SMI_LO = 4'h2;
    localparam logic [3:0] OFS_SMI_HI = 4'h3;
    localparam logic [3:0] OFS_IRQ_LO = 4'h4;
    localparam logic [3:0] OFS_IRQ_HI = 4'h5;
    localparam logic [3:0] OFS_RATE   = 4'h7;
    localparam logic [3:0] OFS_GCFG   = 4'h8;
    localparam logic [3:0] OFS_BANK   = 4'h9;
    localparam logic [3:0] OFS_CCFG   = 4'hA;
    localparam logic [3:0] OFS_RDG    = 4'hB;
    localparam logic [3:0] OFS_LIMH   = 4'hC;
    localparam logic [3:0] OFS_LIML   = 4'hD;
endpackage

// File: rtl/vmon_chan_bank.sv
module vmon_chan_bank #(
    parameter int NCH = 14,
    parameter int DW  = 8,
    parameter int CHW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CHW-1:0] sel,
    input  logic           sel_ok,
    input  logic           wr_cfg,
    input  logic           wr_hi,
    input  logic           wr_lo,
    input  logic [DW-1:0]  wdata,
    input  logic           commit,
    input  logic [CHW-1:0] commit_ch,
    input  logic [DW-1:0]  commit_data,
    output logic [NCH-1:0] en_vec,
    output logic           sel_en,
    output logic [DW-1:0]  sel_rdg,
    output logic [DW-1:0]  sel_hi,
    output logic [DW-1:0]  sel_lo,
    output logic           viol
);
    logic [DW-1:0] rdg_q [NCH];
    logic [DW-1:0] hi_q  [NCH];
    logic [DW-1:0] lo_q  [NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                en_vec[i] <= 1'b0;
                rdg_q[i]  <= '0;
                hi_q[i]   <= '1;
                lo_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (sel_ok && sel == CHW'(i)) begin
                    if (wr_cfg) en_vec[i] <= wdata[0];
                    if (wr_hi)  hi_q[i]   <= wdata;
                    if (wr_lo)  lo_q[i]   <= wdata;
                end
                if (commit && commit_ch == CHW'(i)) rdg_q[i] <= commit_data;
            end
        end
    end

    always_comb begin
        sel_en  = sel_ok ? en_vec[sel] : 1'b0;
        sel_rdg = sel_ok ? rdg_q[sel]  : '0;
        sel_hi  = sel_ok ? hi_q[sel]   : '0;
        sel_lo  = sel_ok ? lo_q[sel]   : '0;
        viol    = (commit_data > hi_q[commit_ch]) || (commit_data < lo_q[commit_ch]);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R5: a reading moves only on a commit addressed to its channel
        a_r5_reading_held: assert property (@(posedge clk) disable iff (!rst_n)
            !(commit && commit_ch == CHW'(g)) |=> $stable(rdg_q[g]));
    end
endmodule

// File: rtl/vmon_event.sv
module vmon_event #(
    parameter int NCH = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_vec,
    input  logic [NCH-1:0] clr_vec,
    input  logic [1:0]     smi_we,
    input  logic [1:0]     irq_we,
    input  logic [7:0]     wdata,
    output logic [NCH-1:0] status_q,
    output logic [NCH-1:0] smi_mask_q,
    output logic [NCH-1:0] irq_mask_q,
    output logic           smi_o,
    output logic           irq_o
);
    localparam int HI_W = NCH - 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q   <= '0;
            smi_mask_q <= '0;
            irq_mask_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
            if (smi_we[0]) smi_mask_q[7:0]     <= wdata;
            if (smi_we[1]) smi_mask_q[NCH-1:8] <= wdata[HI_W-1:0];
            if (irq_we[0]) irq_mask_q[7:0]     <= wdata;
            if (irq_we[1]) irq_mask_q[NCH-1:8] <= wdata[HI_W-1:0];
        end
    end

    always_comb begin
        smi_o = |(status_q & smi_mask_q);
        irq_o = |(status_q & irq_mask_q);
    end

    // R7: bits stay set unless cleared by a write of one
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0));
    // R6: a bit rises only when the checker flagged that channel
    a_r6_set_source: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));
    // R8: an interrupt line needs a pending event
    a_r8_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_o || irq_o) |-> (status_q != '0));
endmodule

// File: rtl/vmon_bank_regs.sv
module vmon_bank_regs #(
    parameter int NCH = 14,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          smp_valid,
    input  logic [3:0]    smp_chan,
    input  logic [DW-1:0] smp_data,
    output logic          smi_o,
    output logic          irq_o
);
    import vmon_pkg::*;

    localparam int CHW = 4;
    localparam int HI_W = NCH - 8;
    localparam logic [7:0] NCH_B = 8'(NCH);
    localparam logic [CHW:0] NCH_W = (CHW+1)'(NCH);

    vm_state_e state_q, state_d;
    logic [7:0] bank_q, rate_q, gcfg_q;
    logic [CHW-1:0] ch_q;
    logic [DW-1:0] dat_q;

    logic [NCH-1:0] en_vec, set_vec, clr_vec, status_q, smi_mask_q, irq_mask_q;
    logic sel_ok, sel_en, viol, accept, commit;
    logic [DW-1:0] sel_rdg, sel_hi, sel_lo;

    assign sel_ok = bank_q < NCH_B;
    assign accept = smp_valid && ({1'b0, smp_chan} < NCH_W) && en_vec[smp_chan];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state: T_WAIT, T_ACCEPT, T_CHAIN, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = accept ? S_CHECK : S_IDLE;
            S_CHECK: state_d = accept ? S_CHECK : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs of the capture stage
    always_comb begin
        commit  = (state_q == S_CHECK);
        set_vec = (commit && viol) ? (NCH'(1) << ch_q) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q   <= '0;
            dat_q  <= '0;
            bank_q <= '0;
            rate_q <= '0;
            gcfg_q <= '0;
        end else begin
            if (accept) begin
                ch_q  <= smp_chan;
                dat_q <= smp_data;
            end
            if (reg_wr && reg_addr == OFS_BANK) bank_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_RATE) rate_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_GCFG) gcfg_q <= reg_wdata;
        end
    end

    always_comb begin
        clr_vec = '0;
        if (reg_wr && reg_addr == OFS_EVT_LO) clr_vec[7:0]     = reg_wdata;
        if (reg_wr && reg_addr == OFS_EVT_HI) clr_vec[NCH-1:8] = reg_wdata[HI_W-1:0];
    end

    vmon_chan_bank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .sel(bank_q[CHW-1:0]), .sel_ok(sel_ok),
        .wr_cfg(reg_wr && reg_addr == OFS_CCFG),
        .wr_hi(reg_wr && reg_addr == OFS_LIMH),
        .wr_lo(reg_wr && reg_addr == OFS_LIML),
        .wdata(reg_wdata[DW-1:0]),
        .commit(commit), .commit_ch(ch_q), .commit_data(dat_q),
        .en_vec(en_vec), .sel_en(sel_en), .sel_rdg(sel_rdg),
        .sel_hi(sel_hi), .sel_lo(sel_lo), .viol(viol)
    );

    vmon_event #(.NCH(NCH)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .smi_we({reg_wr && reg_addr == OFS_SMI_HI, reg_wr && reg_addr == OFS_SMI_LO}),
        .irq_we({reg_wr && reg_addr == OFS_IRQ_HI, reg_wr && reg_addr == OFS_IRQ_LO}),
        .wdata(reg_wdata),
        .status_q(status_q), .smi_mask_q(smi_mask_q), .irq_mask_q(irq_mask_q),
        .smi_o(smi_o), .irq_o(irq_o)
    );

    always_comb begin
        reg_rdata = 8'h00;
        unique case (reg_addr)
            OFS_EVT_LO: reg_rdata = status_q[7:0];
            OFS_EVT_HI: reg_rdata = {{(8-HI_W){1'b0}}, status_q[NCH-1:8]};
            OFS_SMI_LO: reg_rdata = smi_mask_q[7:0];
            OFS_SMI_HI: reg_rdata = {{(8-HI_W){1'b0}}, smi_mask_q[NCH-1:8]};
            OFS_IRQ_LO: reg_rdata = irq_mask_q[7:0];
            OFS_IRQ_HI: reg_rdata = {{(8-HI_W){1'b0}}, irq_mask_q[NCH-1:8]};
            OFS_RATE:   reg_rdata = rate_q;
            OFS_GCFG:   reg_rdata = gcfg_q;
            OFS_BANK:   reg_rdata = bank_q;
            OFS_CCFG:   reg_rdata = {7'b0, sel_en};
            OFS_RDG:    reg_rdata = 8'(sel_rdg);
            OFS_LIMH:   reg_rdata = 8'(sel_hi);
            OFS_LIML:   reg_rdata = 8'(sel_lo);
            default:    reg_rdata = 8'h00;
        endcase
    end

    // R4: a sample for an out-of-range channel never enters the check stage
    a_r4_drop_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && smp_valid && smp_chan >= 4'(NCH)) |=> (state_q == S_IDLE));
    // R3: windowed offsets read zero while the selector is out of range
    a_r3_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q >= NCH_B && reg_addr >= OFS_CCFG && reg_addr <= OFS_LIML) |-> (reg_rdata == 8'h00));
    // R10: a commit is always preceded by an accepted sample
    a_r10_commit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK) |-> $past(accept));
endmodule

// File: tb/vmon_bank_regs_tb.sv
`timescale 1ns/1ps
module vmon_bank_regs_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic sv = 1'b0;
    logic [3:0] sch = '0;
    logic [7:0] sdat = '0;
    logic smi, irq;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    bit [7:0] m_hi [14];
    bit [7:0] m_lo [14];
    bit [7:0] m_rdg [14];
    bit m_en [14];
    bit [13:0] m_st, m_smi, m_irq;
    bit [7:0] m_bank, m_rate, m_gcfg;

    always #2.5 clk = ~clk;

    vmon_bank_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .smp_valid(sv), .smp_chan(sch), .smp_data(sdat),
        .smi_o(smi), .irq_o(irq)
    );

    task automatic chk(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] mread(bit [3:0] a);
        bit ok = m_bank < 14;
        case (a)
            4'h0: return m_st[7:0];
            4'h1: return {2'b0, m_st[13:8]};
            4'h2: return m_smi[7:0];
            4'h3: return {2'b0, m_smi[13:8]};
            4'h4: return m_irq[7:0];
            4'h5: return {2'b0, m_irq[13:8]};
            4'h7: return m_rate;
            4'h8: return m_gcfg;
            4'h9: return m_bank;
            4'hA: return ok ? {7'b0, m_en[m_bank]} : 8'h00;
            4'hB: return ok ? m_rdg[m_bank] : 8'h00;
            4'hC: return ok ? m_hi[m_bank] : 8'h00;
            4'hD: return ok ? m_lo[m_bank] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void mwrite(bit [3:0] a, bit [7:0] d);
        bit ok = m_bank < 14;
        case (a)
            4'h0: m_st = m_st & ~{6'b0, d};
            4'h1: m_st = m_st & ~{d[5:0], 8'b0};
            4'h2: m_smi[7:0] = d;
            4'h3: m_smi[13:8] = d[5:0];
            4'h4: m_irq[7:0] = d;
            4'h5: m_irq[13:8] = d[5:0];
            4'h7: m_rate = d;
            4'h8: m_gcfg = d;
            4'h9: m_bank = d;
            4'hA: if (ok) m_en[m_bank] = d[0];
            4'hC: if (ok) m_hi[m_bank] = d;
            4'hD: if (ok) m_lo[m_bank] = d;
            default: ;
        endcase
    endfunction

    function automatic void msample(bit [3:0] c, bit [7:0] d);
        if (c < 14 && m_en[c]) begin
            m_rdg[c] = d;
            if (d > m_hi[c] || d < m_lo[c]) m_st[c] = 1'b1;
        end
    endfunction

    task automatic wreg(bit [3:0] a, bit [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        mwrite(a, d);
    endtask

    task automatic samp(bit [3:0] c, bit [7:0] d);
        @(negedge clk);
        sv = 1'b1; sch = c; sdat = d;
        @(negedge clk);
        sv = 1'b0;
        @(negedge clk);
        msample(c, d);
    endtask

    task automatic chkreg(string tag, bit [3:0] a);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rdata, mread(a));
    endtask

    task automatic chkirq(string tag);
        #0.2;
        chk({tag, " smi"}, smi, |(m_st & m_smi));
        chk({tag, " irq"}, irq, |(m_st & m_irq));
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            nvec++; nerr++;
            $display("FAIL watchdog act=1 exp=0");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 14; i++) begin
            m_hi[i] = 8'hFF; m_lo[i] = 8'h00; m_rdg[i] = 8'h00; m_en[i] = 1'b0;
        end
        m_st = '0; m_smi = '0; m_irq = '0; m_bank = '0; m_rate = '0; m_gcfg = '0;
        void'($urandom(32'h5EED_0D1E));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R9: reset values over every offset
        for (int a = 0; a < 16; a++) chkreg("R1 reset", 4'(a));
        chkirq("R1");
        for (int c = 0; c < 14; c++) begin
            wreg(4'h9, 8'(c));
            chkreg("R1 hi", 4'hC);
            chkreg("R1 rdg", 4'hB);
        end

        // R2 / R6: channel 3 window, equal value does not trip
        wreg(4'h9, 8'd3); wreg(4'hC, 8'h80); wreg(4'hD, 8'h20); wreg(4'hA, 8'hFF);
        chkreg("R4 enable bit0 only", 4'hA);
        samp(4'd3, 8'h80);
        chkreg("R5 reading", 4'hB);
        chkreg("R6 equal high no event", 4'h0);
        samp(4'd3, 8'h20);
        chkreg("R6 equal low no event", 4'h0);
        samp(4'd3, 8'h81);
        chkreg("R6 above high", 4'h0);
        wreg(4'h2, 8'h08);
        chkirq("R8 smi mask");
        wreg(4'h0, 8'h08);
        chkreg("R7 w1c", 4'h0);
        chkirq("R8 after clear");

        // R6: high channel uses offset 0x01
        wreg(4'h9, 8'd12); wreg(4'hA, 8'h01); wreg(4'hD, 8'h40);
        samp(4'd12, 8'h3F);
        chkreg("R6 low bound ch12", 4'h1);
        wreg(4'h5, 8'h10);
        chkirq("R8 irq mask hi");

        // R4: disabled and out-of-range channels dropped
        samp(4'd5, 8'hFF);
        wreg(4'h9, 8'd5);
        chkreg("R4 disabled reading", 4'hB);
        chkreg("R4 disabled status", 4'h0);
        samp(4'd15, 8'hEE);
        samp(4'd14, 8'hEE);
        chkreg("R4 range status lo", 4'h0);
        chkreg("R4 range status hi", 4'h1);

        // R3: selector out of range
        wreg(4'h9, 8'd14);
        wreg(4'hA, 8'h00); wreg(4'hC, 8'h11); wreg(4'hD, 8'h22);
        for (int a = 10; a < 14; a++) chkreg("R3 window zero", 4'(a));
        wreg(4'h9, 8'd12);
        chkreg("R3 writes ignored en", 4'hA);
        wreg(4'h9, 8'd0);
        chkreg("R3 writes ignored hi", 4'hC);

        // R9: plain bytes
        wreg(4'h7, 8'hA5); wreg(4'h8, 8'h5A); wreg(4'h6, 8'hFF);
        chkreg("R9 rate", 4'h7); chkreg("R9 gcfg", 4'h8); chkreg("R9 unused", 4'h6);

        // R10: back-to-back samples on consecutive edges
        wreg(4'h9, 8'd9); wreg(4'hA, 8'h01); wreg(4'hC, 8'h10);
        @(negedge clk); sv = 1'b1; sch = 4'd3; sdat = 8'h55;
        @(negedge clk); sch = 4'd9; sdat = 8'h77;
        @(negedge clk); sv = 1'b0;
        @(negedge clk);
        msample(4'd3, 8'h55); msample(4'd9, 8'h77);
        chkreg("R10 chained ch9", 4'hB);
        chkreg("R10 chained status hi", 4'h1);
        wreg(4'h9, 8'd3);
        chkreg("R10 chained ch3", 4'hB);

        // R7: set and clear on the same edge, set wins
        @(negedge clk); sv = 1'b1; sch = 4'd3; sdat = 8'hFF;
        @(negedge clk); sv = 1'b0; addr = 4'h0; wdata = 8'h08; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        mwrite(4'h0, 8'h08); msample(4'd3, 8'hFF);
        chkreg("R7 set beats clear", 4'h0);

        // random phase
        for (int n = 0; n < 600; n++) begin
            int op = int'($urandom_range(0, 5));
            case (op)
                0: wreg(4'h9, 8'($urandom_range(0, 15)));
                1: wreg(4'($urandom_range(12, 13)), 8'($urandom));
                2: wreg(4'hA, 8'($urandom));
                3: samp(4'($urandom_range(0, 15)), 8'($urandom));
                4: wreg(4'($urandom_range(0, 1)), 8'($urandom));
                default: wreg(4'($urandom_range(2, 5)), 8'($urandom));
            endcase
            begin
                bit [3:0] a = 4'($urandom_range(0, 15));
                chkreg((a < 2) ? "R6 rnd status" : (a < 6) ? "R8 rnd mask" :
                       (a == 4'hB) ? "R5 rnd reading" : "R2 rnd reg", a);
            end
            chkirq("R8 rnd");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule